// File: doc/BRIEF.md
# Parallel CNF grammar recognizer

This block decides whether a short string of terminal codes can be derived from the start symbol of a context-free grammar in Chomsky Normal Form. The grammar is held in two bit tables: terminal rules A → t and branching rules A → BC. Nonterminal 0 is always the start symbol. The string is held in a small symbol buffer. Software fills the tables and the buffer through a write port while the block is idle. It then pulses `start` with the string length. Some time later the block pulses `done`, and `accept` shows the verdict.

The block does not fill a table of spans in order of span length. It keeps one pebble bit for each derivable span node (A, i, j). It also keeps one edge bit for each pair of a span node and a gapped node inside it. An edge (x, y) means that x derives the text around y with y left as a hole. Each round has four phases: an activate phase, two squaring phases and a pebble phase. The activate phase creates edges from rules whose sibling span is already pebbled. Each squaring phase joins chains of edges. The pebble phase marks every node that has an edge to a pebbled node. About ceil(log2 n) rounds are enough.

Each phase is stepped through its index tuples by counters. It reads a snapshot taken when the phase began, so the result matches a fully parallel update. The run ends early as soon as the goal node (0, 0, n) is pebbled.

Top module: `cnf_recognizer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy`, `done` and `accept` are all 0.
- R2: A `start` while idle with 1 ≤ `str_len` ≤ N_MAX begins a run. In the next cycle `busy` is 1 and `accept` is 0.
- R3: A `start` while idle with `str_len` equal to 0 or greater than N_MAX is ignored. `busy` stays 0, no `done` follows, and `accept` keeps its value.
- R4: While `busy` is 1, `start`, table writes and symbol writes have no effect, either on the current run or on later runs.
- R5: When `done` pulses, `accept` is 1 exactly when the symbols at positions 0..len-1 can be derived from nonterminal 0 under the loaded tables. Position 0 is the leftmost symbol.
- R6: A string of length 1 is accepted exactly when the terminal rule (nonterminal 0 → that code) is set. Such a run performs no rounds.
- R7: `done` is a single-cycle pulse, and `busy` falls in the same cycle. `accept` holds its value from that cycle until the next accepted `start`.
- R8: With `cfg_kind` = 0, address A·T + t sets or clears the terminal rule A → t. With `cfg_kind` = 1, address (A·K + B)·K + C sets or clears the branching rule A → BC. `cfg_val` gives the new bit. A symbol write stores `sym_code` at `sym_pos`. Writes made while idle apply to every later run.
- R9: A run keeps `busy` high for len + 1 + r·((N_MAX+1)³ + 3·K·N_MAX·(N_MAX+1)/2 + 4) cycles, where r is the number of rounds executed. A rejected string executes r = ceil(log2 len) rounds. An accepted string stops after the round that pebbles the goal, so its run is never longer than that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Rule table write strobe (honoured only while idle) |
| cfg_kind | input | 1 | 0 selects the terminal rule table, 1 selects the branching rule table |
| cfg_addr | input | $clog2(K³) | Rule address; encoding given in R8 |
| cfg_val | input | 1 | New value of the addressed rule bit |
| sym_we | input | 1 | Symbol buffer write strobe (honoured only while idle) |
| sym_pos | input | $clog2(N_MAX) | String position to write |
| sym_code | input | $clog2(T) | Terminal code to store |
| start | input | 1 | Run request |
| str_len | input | $clog2(N_MAX+1) | String length for the run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| accept | output | 1 | Verdict of the last run |

## Verification
The assertions assume only that `rst_n` is asserted at time zero. They allow `start` and the write strobes to arrive in any cycle, with any length, so they watch the ignore paths as well as normal runs. The stimulus changes inputs on the falling clock edge. It writes the tables and the symbol buffer only while `busy` is low, except in one deliberate test. That test writes a rule, a symbol and a new start request during a run, and then re-runs the same string to show that none of them took effect. Lengths outside 1..N_MAX are sent only while idle. Expected verdicts come from a span-length table built in the bench for every string of length 1 to N_MAX over the two terminal codes, for two different grammars.

// File: rtl/cnf_pkg.sv
package cnf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INIT,
        PH_CHK,
        PH_ACT,
        PH_SQS,
        PH_SQ,
        PH_PBS,
        PH_PB
    } phase_e;

    // number of rounds needed for a string of the given length: ceil(log2(len))
    function automatic int round_count(input int len);
        int r;
        r = 0;
        for (int s = 0; s < 16; s++) begin
            if ((1 << s) < len) r = s + 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/cnf_tables.sv
module cnf_tables #(
    parameter int N_MAX = 5,
    parameter int K     = 3,
    parameter int T     = 2,
    localparam int TW    = (T > 1) ? $clog2(T) : 1,
    localparam int RAW   = $clog2(K*K*K),
    localparam int PW    = (N_MAX > 1) ? $clog2(N_MAX) : 1,
    localparam int TERMS = K*T,
    localparam int BRS   = K*K*K
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_allow,
    input  logic                  cfg_we,
    input  logic                  cfg_kind,
    input  logic [RAW-1:0]        cfg_addr,
    input  logic                  cfg_val,
    input  logic                  sym_we,
    input  logic [PW-1:0]         sym_pos,
    input  logic [TW-1:0]         sym_code,
    output logic [TERMS-1:0]      term_tab,
    output logic [BRS-1:0]        br_tab,
    output logic [N_MAX*TW-1:0]   sym_flat
);

    typedef struct packed {
        logic [TERMS-1:0]    term;
        logic [BRS-1:0]      br;
        logic [N_MAX*TW-1:0] syms;
    } tab_s;

    tab_s tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_allow && cfg_we) begin
            if (!cfg_kind) begin
                for (int e = 0; e < TERMS; e++) begin
                    if (cfg_addr == RAW'(e)) tab_d.term[e] = cfg_val;
                end
            end else begin
                for (int e = 0; e < BRS; e++) begin
                    if (cfg_addr == RAW'(e)) tab_d.br[e] = cfg_val;
                end
            end
        end
        if (wr_allow && sym_we) begin
            for (int p = 0; p < N_MAX; p++) begin
                if (sym_pos == PW'(p)) tab_d.syms[p*TW +: TW] = sym_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign term_tab = tab_q.term;
    assign br_tab   = tab_q.br;
    assign sym_flat = tab_q.syms;

endmodule

// File: rtl/cnf_sequencer.sv
module cnf_sequencer
    import cnf_pkg::*;
#(
    parameter int N_MAX = 5,
    parameter int K     = 3,
    localparam int LW    = $clog2(N_MAX+1),
    localparam int SPANS = N_MAX*(N_MAX+1)/2,
    localparam int NODES = K*SPANS,
    localparam int NDW   = $clog2(NODES),
    localparam int RW    = $clog2(N_MAX) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LW-1:0]   str_len,
    input  logic            goal_hit,
    output phase_e          phase,
    output logic [LW-1:0]   ci,
    output logic [LW-1:0]   ck,
    output logic [LW-1:0]   cj,
    output logic [NDW-1:0]  nd,
    output logic [LW-1:0]   len,
    output logic            busy,
    output logic            done,
    output logic            accept
);

    typedef struct packed {
        phase_e          ph;
        logic [LW-1:0]   ci;
        logic [LW-1:0]   ck;
        logic [LW-1:0]   cj;
        logic [NDW-1:0]  nd;
        logic            pass;
        logic [RW-1:0]   rnd;
        logic [RW-1:0]   rnd_max;
        logic [LW-1:0]   len;
        logic            done;
        logic            acc;
    } seq_s;

    seq_s s_d, s_q;
    logic len_ok;

    assign len_ok = (str_len != '0) && (str_len <= LW'(N_MAX));

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start && len_ok) begin
                    s_d.ph      = PH_INIT;
                    s_d.ci      = '0;
                    s_d.len     = str_len;
                    s_d.rnd     = '0;
                    s_d.rnd_max = RW'(round_count(int'(str_len)));
                    s_d.acc     = 1'b0;
                end
            end
            PH_INIT: begin
                if (s_q.ci == s_q.len - LW'(1)) s_d.ph = PH_CHK;
                else                            s_d.ci = s_q.ci + LW'(1);
            end
            PH_CHK: begin
                if (goal_hit) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                    s_d.acc  = 1'b1;
                end else if (s_q.rnd == s_q.rnd_max) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                    s_d.acc  = 1'b0;
                end else begin
                    s_d.rnd = s_q.rnd + RW'(1);
                    s_d.ph  = PH_ACT;
                    s_d.ci  = '0;
                    s_d.ck  = '0;
                    s_d.cj  = '0;
                end
            end
            PH_ACT: begin
                if (s_q.cj != LW'(N_MAX)) begin
                    s_d.cj = s_q.cj + LW'(1);
                end else begin
                    s_d.cj = '0;
                    if (s_q.ck != LW'(N_MAX)) begin
                        s_d.ck = s_q.ck + LW'(1);
                    end else begin
                        s_d.ck = '0;
                        if (s_q.ci != LW'(N_MAX)) begin
                            s_d.ci = s_q.ci + LW'(1);
                        end else begin
                            s_d.ph   = PH_SQS;
                            s_d.pass = 1'b0;
                        end
                    end
                end
            end
            PH_SQS: begin
                s_d.ph = PH_SQ;
                s_d.nd = '0;
            end
            PH_SQ: begin
                if (s_q.nd == NDW'(NODES-1)) begin
                    if (!s_q.pass) begin
                        s_d.pass = 1'b1;
                        s_d.ph   = PH_SQS;
                    end else begin
                        s_d.ph = PH_PBS;
                    end
                end else begin
                    s_d.nd = s_q.nd + NDW'(1);
                end
            end
            PH_PBS: begin
                s_d.ph = PH_PB;
                s_d.nd = '0;
            end
            PH_PB: begin
                if (s_q.nd == NDW'(NODES-1)) s_d.ph = PH_CHK;
                else                         s_d.nd = s_q.nd + NDW'(1);
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase  = s_q.ph;
    assign ci     = s_q.ci;
    assign ck     = s_q.ck;
    assign cj     = s_q.cj;
    assign nd     = s_q.nd;
    assign len    = s_q.len;
    assign busy   = (s_q.ph != PH_IDLE);
    assign done   = s_q.done;
    assign accept = s_q.acc;

endmodule

// File: rtl/cnf_pebble_core.sv
module cnf_pebble_core
    import cnf_pkg::*;
#(
    parameter int N_MAX = 5,
    parameter int K     = 3,
    parameter int T     = 2,
    localparam int TW    = (T > 1) ? $clog2(T) : 1,
    localparam int LW    = $clog2(N_MAX+1),
    localparam int SPANS = N_MAX*(N_MAX+1)/2,
    localparam int NODES = K*SPANS,
    localparam int NDW   = $clog2(NODES),
    localparam int TERMS = K*T,
    localparam int TAW   = (TERMS > 1) ? $clog2(TERMS) : 1,
    localparam int BRS   = K*K*K
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  phase_e               phase,
    input  logic [LW-1:0]        ci,
    input  logic [LW-1:0]        ck,
    input  logic [LW-1:0]        cj,
    input  logic [NDW-1:0]       nd,
    input  logic [LW-1:0]        len,
    input  logic [TERMS-1:0]     term_tab,
    input  logic [BRS-1:0]       br_tab,
    input  logic [N_MAX*TW-1:0]  sym_flat,
    output logic                 goal_hit
);

    typedef struct packed {
        logic [NODES-1:0]              peb;
        logic [NODES-1:0]              psnap;
        logic [NODES-1:0][NODES-1:0]   edg;
        logic [NODES-1:0][NODES-1:0]   esnap;
    } core_s;

    core_s c_d, c_q;

    // flat node number of (nonterminal a, span i..j), 0 <= i < j <= N_MAX
    function automatic logic [NDW-1:0] node_of(input int a, input int i, input int j);
        return NDW'(a*SPANS + (j*(j-1))/2 + i);
    endfunction

    logic [TW-1:0]    tok;
    logic [NODES-1:0] row;
    logic [NDW-1:0]   nx, ny, nz;
    int               ii, kk, jj;

    always_comb begin
        c_d = c_q;
        tok = '0;
        row = '0;
        nx  = '0;
        ny  = '0;
        nz  = '0;
        ii  = int'(ci);
        kk  = int'(ck);
        jj  = int'(cj);
        case (phase)
            PH_IDLE: c_d = '0;
            PH_INIT: begin
                for (int p = 0; p < N_MAX; p++) begin
                    if (ci == LW'(p)) begin
                        tok = sym_flat[p*TW +: TW];
                        for (int a = 0; a < K; a++) begin
                            if (int'(tok) < T && term_tab[TAW'(a*T + int'(tok))])
                                c_d.peb[node_of(a, p, p+1)] = 1'b1;
                        end
                    end
                end
            end
            PH_ACT: begin
                if (ci < ck && ck < cj && cj <= len) begin
                    for (int a = 0; a < K; a++) begin
                        for (int b = 0; b < K; b++) begin
                            for (int c = 0; c < K; c++) begin
                                if (br_tab[(a*K+b)*K+c]) begin
                                    nx = node_of(a, ii, jj);
                                    ny = node_of(b, ii, kk);
                                    nz = node_of(c, kk, jj);
                                    if (c_q.peb[nz]) c_d.edg[nx][ny] = 1'b1;
                                    if (c_q.peb[ny]) c_d.edg[nx][nz] = 1'b1;
                                end
                            end
                        end
                    end
                end
            end
            PH_SQS: c_d.esnap = c_q.edg;
            PH_SQ: begin
                if (int'(nd) < NODES) begin
                    row = c_q.edg[nd];
                    for (int z = 0; z < NODES; z++) begin
                        if (c_q.esnap[nd][z]) row = row | c_q.esnap[z];
                    end
                    c_d.edg[nd] = row;
                end
            end
            PH_PBS: c_d.psnap = c_q.peb;
            PH_PB: begin
                if (int'(nd) < NODES)
                    c_d.peb[nd] = c_q.peb[nd] | (|(c_q.edg[nd] & c_q.psnap));
            end
            default: c_d = c_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign goal_hit = (len != '0) && (len <= LW'(N_MAX)) && c_q.peb[node_of(0, 0, int'(len))];

endmodule

// File: rtl/cnf_recognizer.sv
module cnf_recognizer
    import cnf_pkg::*;
#(
    parameter int N_MAX = 5,
    parameter int K     = 3,
    parameter int T     = 2,
    localparam int TW    = (T > 1) ? $clog2(T) : 1,
    localparam int RAW   = $clog2(K*K*K),
    localparam int PW    = (N_MAX > 1) ? $clog2(N_MAX) : 1,
    localparam int LW    = $clog2(N_MAX+1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_kind,
    input  logic [RAW-1:0]  cfg_addr,
    input  logic            cfg_val,
    input  logic            sym_we,
    input  logic [PW-1:0]   sym_pos,
    input  logic [TW-1:0]   sym_code,
    input  logic            start,
    input  logic [LW-1:0]   str_len,
    output logic            busy,
    output logic            done,
    output logic            accept
);

    localparam int SPANS = N_MAX*(N_MAX+1)/2;
    localparam int NODES = K*SPANS;
    localparam int NDW   = $clog2(NODES);
    localparam int TERMS = K*T;
    localparam int BRS   = K*K*K;

    logic [TERMS-1:0]    term_tab;
    logic [BRS-1:0]      br_tab;
    logic [N_MAX*TW-1:0] sym_flat;
    phase_e              phase;
    logic [LW-1:0]       ci, ck, cj, len_q;
    logic [NDW-1:0]      nd;
    logic                goal_hit;
    logic                busy_w;

    cnf_tables #(.N_MAX(N_MAX), .K(K), .T(T)) u_tables (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_allow (!busy_w),
        .cfg_we   (cfg_we),
        .cfg_kind (cfg_kind),
        .cfg_addr (cfg_addr),
        .cfg_val  (cfg_val),
        .sym_we   (sym_we),
        .sym_pos  (sym_pos),
        .sym_code (sym_code),
        .term_tab (term_tab),
        .br_tab   (br_tab),
        .sym_flat (sym_flat)
    );

    cnf_sequencer #(.N_MAX(N_MAX), .K(K)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .str_len  (str_len),
        .goal_hit (goal_hit),
        .phase    (phase),
        .ci       (ci),
        .ck       (ck),
        .cj       (cj),
        .nd       (nd),
        .len      (len_q),
        .busy     (busy_w),
        .done     (done),
        .accept   (accept)
    );

    cnf_pebble_core #(.N_MAX(N_MAX), .K(K), .T(T)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .ci       (ci),
        .ck       (ck),
        .cj       (cj),
        .nd       (nd),
        .len      (len_q),
        .term_tab (term_tab),
        .br_tab   (br_tab),
        .sym_flat (sym_flat),
        .goal_hit (goal_hit)
    );

    assign busy = busy_w;

endmodule

// File: rtl/cnf_recognizer_chk.sv
module cnf_recognizer_chk #(
    parameter int N_MAX = 5,
    parameter int K     = 3,
    parameter int T     = 2,
    localparam int TW    = (T > 1) ? $clog2(T) : 1,
    localparam int RAW   = $clog2(K*K*K),
    localparam int PW    = (N_MAX > 1) ? $clog2(N_MAX) : 1,
    localparam int LW    = $clog2(N_MAX+1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic            cfg_kind,
    input logic [RAW-1:0]  cfg_addr,
    input logic            cfg_val,
    input logic            sym_we,
    input logic [PW-1:0]   sym_pos,
    input logic [TW-1:0]   sym_code,
    input logic            start,
    input logic [LW-1:0]   str_len,
    input logic            busy,
    input logic            done,
    input logic            accept
);

    localparam int NODES     = K*N_MAX*(N_MAX+1)/2;
    localparam int RMAX      = $clog2(N_MAX);
    localparam int PER_ROUND = (N_MAX+1)*(N_MAX+1)*(N_MAX+1) + 3*NODES + 4;
    localparam int RUN_MAX   = N_MAX + 1 + RMAX*PER_ROUND;

    int run_cnt;
    logic len_good;

    assign len_good = (str_len != '0) && (str_len <= LW'(N_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= 0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= 0;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !done && !accept));

    p_run_begins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && len_good) |=> (busy && !accept));

    p_bad_len_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !len_good) |=> (!busy && !done && $stable(accept)));

    p_accept_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept) |-> done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_accept_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(accept));

    p_run_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < RUN_MAX));

endmodule

bind cnf_recognizer cnf_recognizer_chk #(.N_MAX(N_MAX), .K(K), .T(T)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_kind (cfg_kind),
    .cfg_addr (cfg_addr),
    .cfg_val  (cfg_val),
    .sym_we   (sym_we),
    .sym_pos  (sym_pos),
    .sym_code (sym_code),
    .start    (start),
    .str_len  (str_len),
    .busy     (busy),
    .done     (done),
    .accept   (accept)
);

// File: tb/cnf_recognizer_tb.sv
`timescale 1ns/1ps
module cnf_recognizer_tb;

    localparam int N_MAX = 5;
    localparam int K     = 3;
    localparam int T     = 2;
    localparam int TW    = 1;
    localparam int RAW   = $clog2(K*K*K);
    localparam int PW    = $clog2(N_MAX);
    localparam int LW    = $clog2(N_MAX+1);
    localparam int NODES = K*N_MAX*(N_MAX+1)/2;
    localparam int PER_ROUND = (N_MAX+1)*(N_MAX+1)*(N_MAX+1) + 3*NODES + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_kind = 1'b0, cfg_val = 1'b0;
    logic [RAW-1:0] cfg_addr = '0;
    logic sym_we = 1'b0;
    logic [PW-1:0] sym_pos = '0;
    logic [TW-1:0] sym_code = '0;
    logic start = 1'b0;
    logic [LW-1:0] str_len = '0;
    logic busy, done, accept;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    bit gterm [K][T];
    bit gbr   [K][K][K];
    int str_q [N_MAX];

    always #2 clk = ~clk;

    cnf_recognizer #(.N_MAX(N_MAX), .K(K), .T(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_val(cfg_val), .sym_we(sym_we),
        .sym_pos(sym_pos), .sym_code(sym_code), .start(start),
        .str_len(str_len), .busy(busy), .done(done), .accept(accept)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void clear_grammar();
        for (int a = 0; a < K; a++) begin
            for (int t = 0; t < T; t++) gterm[a][t] = 1'b0;
            for (int b = 0; b < K; b++)
                for (int c = 0; c < K; c++) gbr[a][b][c] = 1'b0;
        end
    endfunction

    // span-length table over the bench's own copy of the grammar
    function automatic bit cky_accept(input int len);
        bit tab [N_MAX+1][N_MAX+1][K];
        for (int i = 0; i <= N_MAX; i++)
            for (int j = 0; j <= N_MAX; j++)
                for (int a = 0; a < K; a++) tab[i][j][a] = 1'b0;
        for (int i = 0; i < len; i++)
            for (int a = 0; a < K; a++) tab[i][i+1][a] = gterm[a][str_q[i]];
        for (int sp = 2; sp <= len; sp++)
            for (int i = 0; i + sp <= len; i++)
                for (int k = i + 1; k < i + sp; k++)
                    for (int a = 0; a < K; a++)
                        for (int b = 0; b < K; b++)
                            for (int c = 0; c < K; c++)
                                if (gbr[a][b][c] && tab[i][k][b] && tab[k][i+sp][c])
                                    tab[i][i+sp][a] = 1'b1;
        return tab[0][len][0];
    endfunction

    task automatic cfg_write(input bit kind, input int addr, input bit val);
        cfg_we = 1'b1; cfg_kind = kind; cfg_addr = RAW'(addr); cfg_val = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sym_write(input int pos, input int code);
        sym_we = 1'b1; sym_pos = PW'(pos); sym_code = TW'(code);
        @(negedge clk);
        sym_we = 1'b0;
    endtask

    // R8 encodings: kind 0 addr A*T+t, kind 1 addr (A*K+B)*K+C
    task automatic load_grammar();
        for (int a = 0; a < K; a++)
            for (int t = 0; t < T; t++) cfg_write(1'b0, a*T + t, gterm[a][t]);
        for (int a = 0; a < K; a++)
            for (int b = 0; b < K; b++)
                for (int c = 0; c < K; c++) cfg_write(1'b1, (a*K+b)*K+c, gbr[a][b][c]);
    endtask

    task automatic load_string(input int len);
        for (int p = 0; p < len; p++) sym_write(p, str_q[p]);
    endtask

    task automatic run_check(input int len, input string vreq);
        bit exp;
        int cnt;
        int full;
        exp  = cky_accept(len);
        full = len + 1 + $clog2(len)*PER_ROUND;
        start = 1'b1; str_len = LW'(len);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && accept == 1'b0, "R2 run begins", {busy, accept}, 2);
        cnt = 1;
        while (!done && cnt < 3000) begin
            @(negedge clk);
            if (!done) cnt++;
        end
        chk(done == 1'b1 && busy == 1'b0, "R7 done with busy low", {done, busy}, 2);
        chk(accept == exp, vreq, accept, exp);
        if (exp) chk(cnt <= full, "R9 accepted run length", cnt, full);
        else     chk(cnt == full, "R9 rejected run length", cnt, full);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        chk(accept == exp, "R7 accept held", accept, exp);
    endtask

    task automatic sweep(input string vreq);
        for (int len = 1; len <= N_MAX; len++) begin
            for (int code = 0; code < (1 << len); code++) begin
                for (int p = 0; p < len; p++) str_q[p] = (code >> p) & 1;
                load_string(len);
                if (len == 1) run_check(len, "R6 single symbol");
                else          run_check(len, vreq);
            end
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 190000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int wait_cnt;
        bit exp_a;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && accept == 0, "R1 in reset", {busy, done, accept}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && accept == 0, "R1 after reset", {busy, done, accept}, 0);

        // grammar one: S=0, A=1; S->SS, S->SA, S->b(1), A->a(0)
        clear_grammar();
        gbr[0][0][0] = 1'b1; gbr[0][0][1] = 1'b1;
        gterm[0][1] = 1'b1;  gterm[1][0] = 1'b1;
        load_grammar();
        sweep("R5 grammar one");

        // R4: writes and start during a run are ignored
        str_q[0] = 1; str_q[1] = 0; str_q[2] = 1;
        load_string(3);
        exp_a = cky_accept(3);
        start = 1'b1; str_len = LW'(3);
        @(negedge clk);
        start = 1'b0;
        cfg_write(1'b0, 0*T + 1, 1'b0);
        sym_write(0, 0);
        start = 1'b1; str_len = LW'(1);
        @(negedge clk);
        start = 1'b0;
        wait_cnt = 0;
        while (!done && wait_cnt < 3000) begin @(negedge clk); wait_cnt++; end
        chk(accept == exp_a, "R4 writes during run ignored", accept, exp_a);
        @(negedge clk);
        chk(busy == 0, "R4 start during run ignored", busy, 0);
        run_check(3, "R4 tables unchanged after run");

        // R3: bad lengths while idle
        start = 1'b1; str_len = LW'(0);
        @(negedge clk);
        start = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(busy == 0 && done == 0 && accept == exp_a, "R3 zero length ignored",
                {busy, done, accept}, {2'b00, exp_a});
        end
        start = 1'b1; str_len = LW'(N_MAX + 1);
        @(negedge clk);
        start = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(busy == 0 && done == 0 && accept == exp_a, "R3 long length ignored",
                {busy, done, accept}, {2'b00, exp_a});
        end

        // R8: idle table write changes later verdicts
        str_q[0] = 0; str_q[1] = 1;
        load_string(2);
        run_check(2, "R8 before rule write");
        gterm[0][0] = 1'b1;
        cfg_write(1'b0, 0*T + 0, 1'b1);
        run_check(2, "R8 after rule write");

        // grammar two: S=0, A=1, B=2; S->AB, S->BA, S->SS, A->a, B->b
        clear_grammar();
        gbr[0][1][2] = 1'b1; gbr[0][2][1] = 1'b1; gbr[0][0][0] = 1'b1;
        gterm[1][0] = 1'b1;  gterm[2][1] = 1'b1;
        load_grammar();
        sweep("R8 R5 grammar two");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule